// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

The block converts a list of scatter-gather segments, each a 32-bit bus address and a 32-bit byte length, into a table of region descriptors for a bus-master DMA engine. Segments arrive one at a time on a valid/ready handshake, with a flag on the final segment of a request. Each segment is cut into chunks that never cross a 64 KiB address boundary. Each chunk becomes one descriptor of two 32-bit words, written to table memory through a single 64-bit write port indexed by descriptor number. The block works through one chunk per clock.

Two per-controller variants are selectable by static mode inputs. The split mode serves hosts that misread a zero length field: a full 64 KiB chunk is emitted as two 32 KiB descriptors. The alternate encoding places a word-count-minus-one in the upper half of the length word and drops the end-of-table flag. When the list ends, the block pulses `done` with the number of descriptors. If the table would grow past its capacity, or the request holds no bytes, it reports failure with a count of zero so the caller can fall back to programmed I/O.

Top module: `sgtab_builder`

## Requirements
- R1: Each chunk length is the smaller of the bytes left in the segment and 0x10000 minus the low 16 bits of the current address. The next chunk starts at the current address plus that length, so no descriptor spans a 64 KiB boundary.
- R2: A descriptor write carries the start address in `wr_data[31:0]` and the length word in `wr_data[63:32]`. In normal encoding the byte count sits in length-word bits 15:0 and bits 30:16 are zero.
- R3: In normal encoding with split mode off, a 64 KiB chunk has a length field of 0x0000.
- R4: In normal encoding with split mode on, a 64 KiB chunk becomes two descriptors of 0x8000 bytes. The second one's address is the first one's plus 0x8000.
- R5: In normal encoding, bit 31 of the length word is set on the final descriptor of the table and clear on all others. Zero-length segments produce no descriptor, so the flag lands on the last descriptor actually produced.
- R6: In alternate encoding, the length word is ((count[15:0] >> 2) - 1) modulo 2^16 in bits 31:16, with bits 15:0 zero. No end flag is set, and split mode has no effect.
- R7: Descriptors are written at consecutive indices starting at 0, each exactly once. On success `entry_count` equals the number written. A table of exactly ENTRY_MAX descriptors succeeds.
- R8: If a descriptor beyond ENTRY_MAX would be produced, the build fails. The block still accepts and drops the remaining segments up to the final one, then pulses `done` with `fail`=1 and `entry_count`=0.
- R9: A request with no bytes (every segment of length zero) ends with `fail`=1 and `entry_count`=0.
- R10: `seg_ready` is low while a segment is being chunked and during the `done` cycle. `done` lasts one cycle. The next request is accepted afterwards, with no state carried over.
- R11: After reset `seg_ready`=1, `done`=0 and `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | Split 64 KiB chunks into two halves (static during a build) |
| alt_mode | input | 1 | Alternate length encoding, no end flag (static during a build) |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Final segment of the request |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | IDX_W (8) | Descriptor index |
| wr_data | output | 64 | {length word, address word} |
| done | output | 1 | One-cycle build completion pulse |
| fail | output | 1 | Build failed, valid with done |
| entry_count | output | CNT_W (9) | Descriptors in the table, valid with done |

## Verification
The bench goes after segments that start just below a boundary and span several 64 KiB windows. A wrong boundary cut would show up as a descriptor whose address plus length runs past the window. Full aligned 64 KiB chunks are tried in every mode: a design that mis-gates the split would emit 0x0000 where halves were expected, or split an alternate-encoded chunk. A trailing zero-length segment tests end-flag placement, since a design that flags on segment arrival would leave the table without a marked end. Tables of exactly the capacity and one beyond it test the off-by-one in the limit. An overflowing request followed by a normal one shows whether segments are drained and whether stale counts or flags leak into the next build.

// File: rtl/sgtab_pkg.sv
package sgtab_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_CHUNK = 2'd1,
    ST_FIN   = 2'd2
  } sgtab_state_e;

  localparam logic [16:0] WINDOW_BYTES = 17'h10000;
  localparam logic [16:0] HALF_BYTES   = 17'h08000;
  localparam logic [31:0] END_FLAG     = 32'h8000_0000;

  // Length word for a chunk of cnt bytes (1..65536); end flag not included.
  function automatic logic [31:0] sgtab_len_word(input logic [16:0] cnt,
                                                 input logic alt);
    logic [15:0] words_m1;
    words_m1 = (cnt[15:0] >> 2) - 16'd1;
    if (alt) sgtab_len_word = {words_m1, 16'h0000};
    else     sgtab_len_word = {16'h0000, cnt[15:0]};
  endfunction

endpackage

// File: rtl/sgtab_chunker.sv
module sgtab_chunker
  import sgtab_pkg::*;
(
  input  logic [31:0] cur_addr,
  input  logic [31:0] rem_len,
  input  logic        split_en,
  input  logic        alt_en,
  output logic [16:0] step,
  output logic [31:0] len_word
);

  logic [16:0] room;
  logic [16:0] base_step;
  logic        halve;

  always_comb begin
    room      = WINDOW_BYTES - {1'b0, cur_addr[15:0]};
    base_step = (rem_len >= {15'd0, room}) ? room : rem_len[16:0];
    halve     = split_en && !alt_en && (base_step == WINDOW_BYTES);
    step      = halve ? HALF_BYTES : base_step;
    len_word  = sgtab_len_word(step, alt_en);
  end

endmodule

// File: rtl/sgtab_emitter.sv
module sgtab_emitter #(
  parameter int ENTRY_MAX = 256,
  parameter int CNT_W     = $clog2(ENTRY_MAX + 1),
  parameter int IDX_W     = $clog2(ENTRY_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             produce,
  input  logic [31:0]      ent_addr,
  input  logic [31:0]      ent_len,
  input  logic             finish,
  input  logic             mark_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [63:0]      wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  import sgtab_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             pend_vld_q, pend_vld_d;
  logic [31:0]      pend_addr_q, pend_len_q;
  logic             full, take, flush_mid, flush_end, pend_ld;
  logic [CNT_W-1:0] pend_pos;

  always_comb begin
    full      = (cnt_q == CNT_W'(ENTRY_MAX));
    take      = produce && !full && !ovf_q;
    flush_mid = take && pend_vld_q;
    flush_end = finish && pend_vld_q && !ovf_q;
    pend_pos  = cnt_q - CNT_W'(1);
    pend_ld   = take;

    cnt_d      = cnt_q;
    ovf_d      = ovf_q;
    pend_vld_d = pend_vld_q;
    if (finish) begin
      cnt_d      = '0;
      ovf_d      = 1'b0;
      pend_vld_d = 1'b0;
    end else begin
      if (produce && (full || ovf_q)) ovf_d = 1'b1;
      if (take) begin
        cnt_d      = cnt_q + CNT_W'(1);
        pend_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      pend_vld_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      ovf_q      <= ovf_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      pend_addr_q <= ent_addr;
      pend_len_q  <= ent_len;
    end
  end

  assign wr_en   = flush_mid || flush_end;
  assign wr_idx  = pend_pos[IDX_W-1:0];
  assign wr_data = {pend_len_q | ((flush_end && mark_en) ? END_FLAG : 32'h0),
                    pend_addr_q};
  assign count   = cnt_q;
  assign ovf     = ovf_q;

  // R7: the held entry index never leaves the table
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (pend_pos < CNT_W'(ENTRY_MAX)));

  // R7: the count never passes capacity
  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ENTRY_MAX));

  // R8: once overflowed, nothing more is written until the build ends
  a_r8_no_write_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> !wr_en);

endmodule

// File: rtl/sgtab_builder.sv
module sgtab_builder
  import sgtab_pkg::*;
#(
  parameter int ENTRY_MAX = 256,
  parameter int CNT_W     = $clog2(ENTRY_MAX + 1),
  parameter int IDX_W     = $clog2(ENTRY_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_mode,
  input  logic             alt_mode,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [31:0]      seg_len,
  input  logic             seg_last,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [63:0]      wr_data,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] entry_count
);

  sgtab_state_e state_q, state_d;
  logic [31:0]  addr_q, addr_d;
  logic [31:0]  rem_q, rem_d;
  logic         last_q, last_d;
  logic         seg_ld;
  logic         accept, produce, finish;
  logic [16:0]  step;
  logic [31:0]  len_word;
  logic [31:0]  rem_after;
  logic [CNT_W-1:0] count;
  logic         ovf;

  sgtab_chunker u_chunk (
    .cur_addr (addr_q),
    .rem_len  (rem_q),
    .split_en (split_mode),
    .alt_en   (alt_mode),
    .step     (step),
    .len_word (len_word)
  );

  sgtab_emitter #(
    .ENTRY_MAX (ENTRY_MAX),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .produce  (produce),
    .ent_addr (addr_q),
    .ent_len  (len_word),
    .finish   (finish),
    .mark_en  (!alt_mode),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .count    (count),
    .ovf      (ovf)
  );

  always_comb begin
    seg_ready = (state_q == ST_LOAD);
    accept    = seg_valid && seg_ready;
    rem_after = rem_q - {15'd0, step};
    produce   = 1'b0;
    finish    = 1'b0;
    seg_ld    = 1'b0;
    state_d   = state_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    last_d    = last_q;

    unique case (state_q)
      ST_LOAD: begin
        if (accept) begin
          if (ovf || (seg_len == 32'd0)) begin
            state_d = seg_last ? ST_FIN : ST_LOAD;
          end else begin
            seg_ld  = 1'b1;
            addr_d  = seg_addr;
            rem_d   = seg_len;
            last_d  = seg_last;
            state_d = ST_CHUNK;
          end
        end
      end
      ST_CHUNK: begin
        if (ovf) begin
          state_d = last_q ? ST_FIN : ST_LOAD;
        end else begin
          produce = 1'b1;
          seg_ld  = 1'b1;
          addr_d  = addr_q + {15'd0, step};
          rem_d   = rem_after;
          if (rem_after == 32'd0) state_d = last_q ? ST_FIN : ST_LOAD;
        end
      end
      ST_FIN: begin
        finish  = 1'b1;
        state_d = ST_LOAD;
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOAD;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (seg_ld) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      last_q <= last_d;
    end
  end

  assign done        = (state_q == ST_FIN);
  assign fail        = ovf || (count == '0);
  assign entry_count = fail ? '0 : count;

  // Checking views of the written descriptor
  logic [17:0] chk_len, chk_span;
  assign chk_len  = (wr_data[47:32] == 16'h0) ? 18'h10000 : {2'b0, wr_data[47:32]};
  assign chk_span = {2'b0, wr_data[15:0]} + chk_len;

  // R1: a normal-encoded descriptor stays inside its 64 KiB window
  a_r1_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !alt_mode) |-> (chk_span <= 18'h10000));

  // R4: with split on, no normal descriptor carries a full-window length
  a_r4_no_full_field: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && split_mode && !alt_mode) |-> (wr_data[47:32] != 16'h0));

  // R5: the end flag appears only on the write made in the completion cycle
  a_r5_mark_final: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !alt_mode && wr_data[63]) |-> done);

  // R8: a failed build reports zero descriptors
  a_r8_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (entry_count == '0));

  // R10: done lasts one cycle and no segment is taken with it
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_no_ready_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !seg_ready);

endmodule

// File: tb/sgtab_builder_test.sv
`timescale 1ns/1ps
module sgtab_builder_test;

  localparam int EMAX  = 256;
  localparam int CNT_W = $clog2(EMAX + 1);
  localparam int IDX_W = $clog2(EMAX);

  logic             clk, rst_n;
  logic             split_mode, alt_mode;
  logic             seg_valid, seg_ready, seg_last;
  logic [31:0]      seg_addr, seg_len;
  logic             wr_en, done, fail;
  logic [IDX_W-1:0] wr_idx;
  logic [63:0]      wr_data;
  logic [CNT_W-1:0] entry_count;

  sgtab_builder #(.ENTRY_MAX(EMAX)) uut (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .alt_mode(alt_mode),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done), .fail(fail), .entry_count(entry_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] mem [EMAX];
  always @(posedge clk) if (wr_en) mem[wr_idx] <= wr_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] s_addr [4];
  logic [31:0] s_len  [4];
  logic [63:0] exp_ent [EMAX];
  int          exp_n;
  bit          exp_fail;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int n, input bit split, input bit alt);
    longint a, r, room, c;
    logic [15:0] q;
    logic [31:0] lw;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      a = s_addr[i];
      r = s_len[i];
      while (r > 0) begin
        room = 64'h10000 - (a & 64'hFFFF);
        c = (r < room) ? r : room;
        if (split && !alt && c == 64'h10000) c = 64'h8000;
        q  = 16'((c & 64'hFFFF) >> 2) - 16'd1;
        lw = alt ? {q, 16'h0} : {16'h0, 16'(c & 64'hFFFF)};
        if (exp_n < EMAX) exp_ent[exp_n] = {lw, 32'(a)};
        exp_n++;
        a = (a + c) & 64'hFFFF_FFFF;
        r = r - c;
      end
    end
    exp_fail = (exp_n == 0) || (exp_n > EMAX);
    if (!exp_fail && !alt) exp_ent[exp_n-1][63] = 1'b1;
  endtask

  task automatic run_build(input string req, input int n,
                           input bit split, input bit alt);
    model(n, split, alt);
    for (int i = 0; i < EMAX; i++) mem[i] = 64'hA5A5_A5A5_5A5A_5A5A;
    @(negedge clk);
    split_mode = split;
    alt_mode   = alt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seg_valid = 1'b1;
      seg_addr  = s_addr[i];
      seg_len   = s_len[i];
      seg_last  = (i == n - 1);
      while (!seg_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    chk(!seg_ready, "R10", "ready after final segment", seg_ready, 0);
    while (!done) @(negedge clk);
    chk(fail == exp_fail, req, "fail flag", fail, exp_fail);
    chk(entry_count == (exp_fail ? 0 : exp_n), req, "entry count",
        entry_count, exp_fail ? 0 : exp_n);
    @(negedge clk);
    chk(!done && seg_ready, "R10", "done pulse ended, ready back",
        {done, seg_ready}, 2'b01);
    if (!exp_fail)
      for (int i = 0; i < exp_n; i++)
        chk(mem[i] == exp_ent[i], req, $sformatf("entry %0d", i),
            mem[i], exp_ent[i]);
  endtask

  task automatic t_single();
    s_addr[0] = 32'h1000_0100; s_len[0] = 32'h200;
    run_build("R2", 1, 1'b0, 1'b0);
  endtask

  task automatic t_cross();
    s_addr[0] = 32'h0000_FF00; s_len[0] = 32'h300;
    s_addr[1] = 32'h0003_FFF0; s_len[1] = 32'h0002_0020;
    run_build("R1", 2, 1'b0, 1'b0);
  endtask

  task automatic t_full();
    s_addr[0] = 32'h0002_0000; s_len[0] = 32'h0001_0000;
    s_addr[1] = 32'h0005_0000; s_len[1] = 32'h0001_0000;
    run_build("R3", 2, 1'b0, 1'b0);
  endtask

  task automatic t_split();
    s_addr[0] = 32'h0002_0000; s_len[0] = 32'h0001_0000;
    s_addr[1] = 32'h0007_C000; s_len[1] = 32'h0001_8000;
    run_build("R4", 2, 1'b1, 1'b0);
  endtask

  task automatic t_zero_tail();
    s_addr[0] = 32'h0000_0000; s_len[0] = 32'h0;
    s_addr[1] = 32'h0010_0010; s_len[1] = 32'h80;
    s_addr[2] = 32'h0020_0000; s_len[2] = 32'h0;
    run_build("R5", 3, 1'b0, 1'b0);
  endtask

  task automatic t_alt();
    s_addr[0] = 32'h0000_0100; s_len[0] = 32'h40;
    s_addr[1] = 32'h0001_0000; s_len[1] = 32'h0001_0000;
    s_addr[2] = 32'h0002_FFF8; s_len[2] = 32'h10;
    run_build("R6", 3, 1'b1, 1'b1);
  endtask

  task automatic t_empty();
    s_addr[0] = 32'h0000_4000; s_len[0] = 32'h0;
    s_addr[1] = 32'h0000_8000; s_len[1] = 32'h0;
    run_build("R9", 2, 1'b0, 1'b0);
  endtask

  task automatic t_max();
    s_addr[0] = 32'h4000_0000; s_len[0] = 32'h0100_0000;
    run_build("R7", 1, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    s_addr[0] = 32'h0000_0000; s_len[0] = 32'h0101_0000;
    s_addr[1] = 32'h0800_0000; s_len[1] = 32'h100;
    run_build("R8", 2, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; seg_valid = 1'b0; seg_last = 1'b0;
    seg_addr = '0; seg_len = '0; split_mode = 1'b0; alt_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_ready && !done && !wr_en, "R11", "reset outputs",
        {seg_ready, done, wr_en}, 3'b100);
    t_single();
    t_cross();
    t_full();
    t_split();
    t_zero_tail();
    t_alt();
    t_empty();
    t_max();
    t_overflow();
    t_single();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule